// File: doc/BRIEF.md
# BT.656 Stream Receiver with Variable Blanking

This block takes an 8-bit 4:2:2 digital video byte stream in the ITU-R BT.656 format. It finds the embedded timing reference codes and tracks the field, vertical-blanking and horizontal-blanking state that those codes carry. It delivers the active picture bytes one per clock, with a valid strobe, a component tag (luma, blue difference or red difference), a start-of-line marker and a start-of-field marker.

The source that feeds it runs on a free-running clock. Because of that, the number of blanking bytes between the end of one line's picture and the start of the next line's picture can change from line to line. The receiver therefore never counts samples across blanking. Each line's capture starts at the byte that follows a detected start-of-active-video code and stops at the next end-of-active-video code. A three-byte delay line holds data back until the receiver knows whether a run of FF 00 00 is a real timing preamble (which is discarded) or picture data (which is emitted). The nominal black level of the luma stream is 16 and its chroma zero is 128. The receiver passes all codes through unchanged.

Three state machines form the design. The preamble machine has the states HUNT, GOT_FF, GOT_Z1 and GOT_Z2. The transitions are: FF moves to GOT_FF; 00 moves on from GOT_FF to GOT_Z1 and from GOT_Z1 to GOT_Z2; FF returns to GOT_FF from any state; any other byte returns to HUNT; the byte taken in GOT_Z2 is the code word, and the machine then leaves GOT_Z2. The entry capture machine has the states BLANK and ACTIVE. A valid start code with V=0 moves it to ACTIVE, and any other valid code moves it to BLANK. The emit machine has the states WAIT, RUN and FULL. A valid start code moves it to RUN. Emitting the last allowed byte moves it from RUN to FULL.

Top module: `bt656_rx`

## Requirements
- R1: While reset is low and in the first cycle after it is released: sample_vld_o=0, sol_o=0, sof_o=0, code_err_o=0, ovf_o=0, field_o=0, vblank_o=1 and hblank_o=1.
- R2: A timing code is FF,00,00 followed by a code word. In the code word, bit 7 is 1, bit 6 is F, bit 5 is V and bit 4 is H (0 = start of active video, 1 = end). Bits 3:0 are {V^H, F^H, F^V, F^V^H}. On a valid code, field_o, vblank_o and hblank_o take F, V and H in the cycle that follows the clock edge that samples the code word.
- R3: The active bytes of a line are tagged in the repeating order Cb, Y, Cr, Y. The tag encoding on sample_kind_o is 0 = Y, 1 = Cb and 2 = Cr.
- R4: A byte sampled at clock edge k between a valid start code with V=0 and the next valid end code appears on sample_o with sample_vld_o=1 after edge k+3. sol_o is high with the first byte of each line. No other byte raises sample_vld_o.
- R5: A code word whose bit 7 is 1 but whose protection bits disagree with F, V and H is ignored. code_err_o pulses for one cycle after it, and field_o, vblank_o and hblank_o keep their values.
- R6: sof_o is high with the first emitted byte that follows any valid code with V=1.
- R7: The number of blanking bytes between an end code and the following start code may be any value, including zero. The emitted bytes and tags of each line do not depend on it.
- R8: At most ACT_BYTES bytes are emitted per line. Any byte beyond that is dropped, and ovf_o is high from the cycle that byte would have appeared until the next valid start code.
- R9: Inside active video, FF and 00 bytes are emitted as picture data unless the full FF,00,00 preamble is followed by a valid code word. An invalid code word there is also emitted as data.
- R10: Bytes that follow a valid start code with V=1 are never emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Incoming stream byte |
| sample_o | output | 8 | Emitted active byte |
| sample_kind_o | output | 2 | Component tag: 0 Y, 1 Cb, 2 Cr |
| sample_vld_o | output | 1 | sample_o carries an active byte |
| sol_o | output | 1 | First active byte of a line |
| sof_o | output | 1 | First active byte of a field |
| field_o | output | 1 | F bit of the last valid code |
| vblank_o | output | 1 | V bit of the last valid code |
| hblank_o | output | 1 | H bit of the last valid code |
| code_err_o | output | 1 | One-cycle pulse on a code word with bad protection bits |
| ovf_o | output | 1 | Bytes of the current line were dropped for excess length |

## Verification
The bench varies the blanking gap between lines, including a gap of zero bytes. A receiver that counts samples instead of anchoring on the start code would emit blanking bytes or shift the Cb/Y/Cr phase of a line. The bench places FF,00,00 runs inside active video, each followed by a byte with bit 7 clear or by a corrupted code word. A design that discards bytes too early would lose picture data, and one that acts on bad codes would flip the field or blanking state. A line longer than the limit checks three things: that the limit is not off by one, that ovf_o is set in the exact cycle, and that the next start code clears ovf_o. A vertical-blanking line that carries data checks that nothing leaks out and that sof_o is placed correctly.

// File: rtl/vrx_pkg.sv
package vrx_pkg;

    // Length of the FF 00 00 preamble that precedes every code word
    localparam int PRE_LEN = 3;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_GOT_FF,
        ST_GOT_Z1,
        ST_GOT_Z2
    } trs_st_t;

    typedef enum logic {
        CS_BLANK,
        CS_ACTIVE
    } cap_st_t;

    typedef enum logic [1:0] {
        EM_WAIT,
        EM_RUN,
        EM_FULL
    } em_st_t;

    typedef enum logic [1:0] {
        K_Y  = 2'd0,
        K_CB = 2'd1,
        K_CR = 2'd2
    } kind_t;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } tflags_t;

    typedef struct packed {
        logic [7:0] b;
        logic       act;
    } pbyte_t;

    function automatic logic [3:0] prot_bits(input logic f, input logic v, input logic h);
        return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/vrx_trs_detect.sv
module vrx_trs_detect
    import vrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] din,
    output logic       hit_o,
    output tflags_t    code_o,
    output tflags_t    flags_q,
    output logic       err_q
);

    trs_st_t st, st_nx;
    logic    at_word;
    logic    prot_ok;

    assign at_word = (st == ST_GOT_Z2) && din[7];
    assign code_o  = '{f: din[6], v: din[5], h: din[4]};
    assign prot_ok = (din[3:0] == prot_bits(din[6], din[5], din[4]));
    assign hit_o   = at_word && prot_ok;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_HUNT;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_HUNT:   st_nx = (din == 8'hFF) ? ST_GOT_FF : ST_HUNT;
            ST_GOT_FF: begin
                if (din == 8'h00)      st_nx = ST_GOT_Z1;
                else if (din == 8'hFF) st_nx = ST_GOT_FF;
                else                   st_nx = ST_HUNT;
            end
            ST_GOT_Z1: begin
                if (din == 8'h00)      st_nx = ST_GOT_Z2;
                else if (din == 8'hFF) st_nx = ST_GOT_FF;
                else                   st_nx = ST_HUNT;
            end
            ST_GOT_Z2: st_nx = (din == 8'hFF) ? ST_GOT_FF : ST_HUNT;
            default:   st_nx = ST_HUNT;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '{f: 1'b0, v: 1'b1, h: 1'b1};
            err_q   <= 1'b0;
        end else begin
            if (hit_o) flags_q <= code_o;
            err_q <= at_word && !prot_ok;
        end
    end

    // R2: blanking/field state moves only after a valid code word
    a_r2_flags_on_code: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flags_q) |-> $past(hit_o));

    // R5: a rejected code word leaves the state untouched
    a_r5_err_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $stable(flags_q));

endmodule

// File: rtl/vrx_sample_pipe.sv
module vrx_sample_pipe
    import vrx_pkg::*;
#(
    parameter int DEPTH = PRE_LEN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] din,
    input  logic       tag_in,
    input  logic       kill,
    output logic [7:0] tail_b,
    output logic       tail_act
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
        pbyte_t q;
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= '{b: din, act: tag_in && !kill};
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= '{b: g_stg[i-1].q.b, act: g_stg[i-1].q.act && !kill};
            end
        end
    end

    logic last_act;
    assign last_act = g_stg[DEPTH-1].q.act;
    assign tail_b   = g_stg[DEPTH-1].q.b;
    assign tail_act = last_act && !kill;

    // R9: a confirmed preamble never leaves a byte flagged as picture data
    a_r9_kill_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !last_act);

endmodule

// File: rtl/vrx_active_emit.sv
module vrx_active_emit
    import vrx_pkg::*;
#(
    parameter int ACT_BYTES = 1440
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_b,
    input  logic       in_act,
    input  logic       sav_hit,
    input  logic       vb_hit,
    output logic [7:0] byte_q,
    output logic [1:0] kind_q,
    output logic       vld_q,
    output logic       sol_q,
    output logic       sof_q,
    output logic       ovf_q
);

    localparam int CW = $clog2(ACT_BYTES + 1);
    localparam logic [CW-1:0] LAST = CW'(ACT_BYTES - 1);

    em_st_t        st, st_nx;
    logic [CW-1:0] cnt;
    logic          sof_pend;
    logic          emit;
    logic          drop;
    kind_t         kind_nx;

    assign emit = (st == EM_RUN) && in_act;
    assign drop = (st == EM_FULL) && in_act;

    always_comb begin
        unique case (cnt[1:0])
            2'd0:    kind_nx = K_CB;
            2'd2:    kind_nx = K_CR;
            default: kind_nx = K_Y;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= EM_WAIT;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (sav_hit) begin
            st_nx = EM_RUN;
        end else begin
            unique case (st)
                EM_WAIT: st_nx = EM_WAIT;
                EM_RUN:  st_nx = (in_act && cnt == LAST) ? EM_FULL : EM_RUN;
                EM_FULL: st_nx = EM_FULL;
                default: st_nx = EM_WAIT;
            endcase
        end
    end

    // outputs and line bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            sof_pend <= 1'b0;
            byte_q   <= '0;
            kind_q   <= K_Y;
            vld_q    <= 1'b0;
            sol_q    <= 1'b0;
            sof_q    <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            vld_q  <= emit;
            sol_q  <= emit && (cnt == '0);
            sof_q  <= emit && sof_pend;
            byte_q <= in_b;
            kind_q <= kind_nx;

            if (sav_hit)   cnt <= '0;
            else if (emit) cnt <= cnt + CW'(1);

            if (vb_hit)    sof_pend <= 1'b1;
            else if (emit) sof_pend <= 1'b0;

            if (sav_hit)   ovf_q <= 1'b0;
            else if (drop) ovf_q <= 1'b1;
        end
    end

    // R8: nothing leaves once the line limit has been reached
    a_r8_full_blocks_output: assert property (@(posedge clk) disable iff (!rst_n)
        (st == EM_FULL) |=> !vld_q);

    // R3: consecutive bytes within a line never repeat a tag
    a_r3_kind_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && $past(vld_q) && !sol_q) |-> (kind_q != $past(kind_q)));

    // R4: line marker only rides on a valid byte
    a_r4_sol_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
        sol_q |-> vld_q);

    // R6: field marker coincides with a line start
    a_r6_sof_is_line_start: assert property (@(posedge clk) disable iff (!rst_n)
        sof_q |-> sol_q);

endmodule

// File: rtl/bt656_rx.sv
module bt656_rx
    import vrx_pkg::*;
#(
    parameter int ACT_BYTES = 1440
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] din,
    output logic [7:0] sample_o,
    output logic [1:0] sample_kind_o,
    output logic       sample_vld_o,
    output logic       sol_o,
    output logic       sof_o,
    output logic       field_o,
    output logic       vblank_o,
    output logic       hblank_o,
    output logic       code_err_o,
    output logic       ovf_o
);

    logic    hit;
    tflags_t code;
    tflags_t flags;
    cap_st_t cap_st, cap_st_nx;
    logic [7:0] tail_b;
    logic       tail_act;

    vrx_trs_detect u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .hit_o   (hit),
        .code_o  (code),
        .flags_q (flags),
        .err_q   (code_err_o)
    );

    // entry-side capture window, opened and closed only by valid codes
    always_ff @(posedge clk) begin
        if (!rst_n) cap_st <= CS_BLANK;
        else        cap_st <= cap_st_nx;
    end

    always_comb begin
        cap_st_nx = cap_st;
        unique case (cap_st)
            CS_BLANK:  if (hit && !code.h && !code.v) cap_st_nx = CS_ACTIVE;
            CS_ACTIVE: if (hit && (code.h || code.v)) cap_st_nx = CS_BLANK;
            default:   cap_st_nx = CS_BLANK;
        endcase
    end

    vrx_sample_pipe #(.DEPTH(PRE_LEN)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .tag_in   (cap_st == CS_ACTIVE),
        .kill     (hit),
        .tail_b   (tail_b),
        .tail_act (tail_act)
    );

    vrx_active_emit #(.ACT_BYTES(ACT_BYTES)) u_emit (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_b    (tail_b),
        .in_act  (tail_act),
        .sav_hit (hit && !code.h),
        .vb_hit  (hit && code.v),
        .byte_q  (sample_o),
        .kind_q  (sample_kind_o),
        .vld_q   (sample_vld_o),
        .sol_q   (sol_o),
        .sof_q   (sof_o),
        .ovf_q   (ovf_o)
    );

    assign field_o  = flags.f;
    assign vblank_o = flags.v;
    assign hblank_o = flags.h;

    // R10: no picture byte is emitted while the vertical blanking state holds
    a_r10_vld_outside_vblank: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |-> !vblank_o);

endmodule

// File: tb/bt656_rx_bench.sv
module bt656_rx_bench;

    localparam int ACT = 1440;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h10;
    logic [7:0] sample_o;
    logic [1:0] sample_kind_o;
    logic       sample_vld_o, sol_o, sof_o, field_o, vblank_o, hblank_o, code_err_o, ovf_o;

    bt656_rx #(.ACT_BYTES(ACT)) u_bt656_rx (
        .clk(clk), .rst_n(rst_n), .din(din),
        .sample_o(sample_o), .sample_kind_o(sample_kind_o), .sample_vld_o(sample_vld_o),
        .sol_o(sol_o), .sof_o(sof_o), .field_o(field_o), .vblank_o(vblank_o),
        .hblank_o(hblank_o), .code_err_o(code_err_o), .ovf_o(ovf_o)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [7:0] b;
        logic [1:0] k;
        logic       sol;
        logic       sof;
    } smp_t;

    smp_t       exp_smp[int];
    logic [2:0] exp_flag[int];
    bit         exp_err[int];
    bit         ovf_set_at[int];
    bit         ovf_clr_at[int];

    // model view of the outputs
    logic mf_f = 1'b0, mf_v = 1'b1, mf_h = 1'b1, m_ovf = 1'b0;
    // model view of the line being received
    bit m_act = 0, m_sofp = 0;
    int m_cnt = 0;

    int    n_chk = 0, n_fail = 0;
    bit    mon_on = 0, done = 0;
    string phase = "R1 reset";

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] cycle %0d actual=%0h expected=%0h", req, phase, cyc, act, exp);
        end
    endtask

    function automatic logic [1:0] kind_of(input int c);
        case (c % 4)
            0:       return 2'd1;
            2:       return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [7:0] code_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] pay(input int i, input int seed);
        return 8'(16 + ((i * 37 + seed * 11) % 220));
    endfunction

    task automatic drive(input logic [7:0] b);
        din = b;
        @(negedge clk);
    endtask

    task automatic send_data(input logic [7:0] b);
        if (m_act) begin
            if (m_cnt < ACT) begin
                smp_t s;
                s.b = b; s.k = kind_of(m_cnt); s.sol = (m_cnt == 0); s.sof = m_sofp;
                m_sofp = 0;
                exp_smp[cyc + 4] = s;
                m_cnt++;
            end else begin
                ovf_set_at[cyc + 4] = 1;
            end
        end
        drive(b);
    endtask

    task automatic send_trs(input logic f, input logic v, input logic h);
        drive(8'hFF); drive(8'h00); drive(8'h00);
        exp_flag[cyc + 1] = {f, v, h};
        if (!h) begin
            ovf_clr_at[cyc + 1] = 1;
            m_cnt = 0;
        end
        m_act = !h && !v;
        if (v) m_sofp = 1;
        drive(code_word(f, v, h));
    endtask

    task automatic send_bad_trs(input logic f, input logic v, input logic h);
        send_data(8'hFF); send_data(8'h00); send_data(8'h00);
        exp_err[cyc + 1] = 1;
        send_data(code_word(f, v, h) ^ 8'h01);
    endtask

    task automatic send_blank(input int n);
        for (int i = 0; i < n; i++) send_data((i % 2 == 0) ? 8'h80 : 8'h10);
    endtask

    task automatic send_line(input logic f, input logic v, input int nblank, input int nact, input int seed);
        send_trs(f, v, 1'b1);
        send_blank(nblank);
        send_trs(f, v, 1'b0);
        for (int i = 0; i < nact; i++) send_data(pay(i, seed));
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (mon_on) begin
            bit e_err, e_vld;
            if (exp_flag.exists(cyc)) {mf_f, mf_v, mf_h} = exp_flag[cyc];
            if (ovf_clr_at.exists(cyc)) m_ovf = 1'b0;
            if (ovf_set_at.exists(cyc)) m_ovf = 1'b1;
            e_err = exp_err.exists(cyc);
            e_vld = exp_smp.exists(cyc);
            chk("R2", {field_o, vblank_o, hblank_o} == {mf_f, mf_v, mf_h},
                {field_o, vblank_o, hblank_o}, {mf_f, mf_v, mf_h});
            chk("R5", code_err_o == e_err, code_err_o, e_err);
            chk("R8", ovf_o == m_ovf, ovf_o, m_ovf);
            chk("R4", sample_vld_o == e_vld, sample_vld_o, e_vld);
            if (e_vld && sample_vld_o) begin
                smp_t s;
                s = exp_smp[cyc];
                chk("R4", sample_o == s.b, sample_o, s.b);
                chk("R3", sample_kind_o == s.k, sample_kind_o, s.k);
                chk("R4", sol_o == s.sol, sol_o, s.sol);
                chk("R6", sof_o == s.sof, sof_o, s.sof);
            end else begin
                chk("R4", !sol_o, sol_o, 0);
                chk("R6", !sof_o, sof_o, 0);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog [%s] actual=running expected=finished", phase);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        chk("R1", sample_vld_o == 0, sample_vld_o, 0);
        chk("R1", {sol_o, sof_o, code_err_o, ovf_o} == 4'b0, {sol_o, sof_o, code_err_o, ovf_o}, 0);
        chk("R1", {field_o, vblank_o, hblank_o} == 3'b011, {field_o, vblank_o, hblank_o}, 3);
        rst_n = 1'b1;
        mon_on = 1;
        @(negedge clk);
        chk("R1", {field_o, vblank_o, hblank_o, sample_vld_o} == 4'b0110,
            {field_o, vblank_o, hblank_o, sample_vld_o}, 6);

        phase = "R10 vertical blanking lines carry data";
        send_line(1'b0, 1'b1, 6, 8, 1);
        send_line(1'b0, 1'b1, 6, 8, 2);

        phase = "R3 first active lines";
        send_line(1'b0, 1'b0, 8, 16, 3);
        send_line(1'b0, 1'b0, 8, 12, 4);

        phase = "R7 variable blanking";
        send_line(1'b0, 1'b0, 0, 8, 5);
        send_line(1'b0, 1'b0, 13, 8, 6);
        send_line(1'b0, 1'b0, 1, 9, 7);
        send_line(1'b0, 1'b0, 27, 8, 8);
        send_line(1'b0, 1'b0, 5, 10, 9);

        phase = "R9 reserved bytes inside picture";
        send_line(1'b0, 1'b0, 4, 3, 10);
        send_data(8'hFF); send_data(8'h00); send_data(8'h00); send_data(8'h05);
        send_data(8'h40);
        send_data(8'hFF); send_data(8'h00); send_data(8'h41);
        send_bad_trs(1'b0, 1'b0, 1'b0);
        send_data(8'h42); send_data(8'h43);

        phase = "R5 invalid code in blanking";
        send_trs(1'b0, 1'b0, 1'b1);
        send_blank(3);
        send_bad_trs(1'b1, 1'b1, 1'b0);
        send_blank(3);
        send_trs(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) send_data(pay(i, 11));

        phase = "R8 overlong line";
        send_line(1'b0, 1'b0, 4, ACT + 5, 12);
        send_line(1'b0, 1'b0, 4, 8, 13);

        phase = "R6 second field";
        send_line(1'b1, 1'b1, 6, 4, 14);
        send_line(1'b1, 1'b0, 6, 10, 15);
        send_line(1'b1, 1'b0, 2, 6, 16);

        send_trs(1'b1, 1'b0, 1'b1);
        send_blank(10);
        done = 1;
        finish_run();
    end

endmodule